// File: doc/BRIEF.md
# Single-Owner Line Directory Controller

This block is the home-side directory of a distributed shared-memory node. Every line whose home is this node has one directory entry: a held flag and the ID of the single node that caches it. A remote node asks for a line by presenting its own node ID and a line address. The line address has two fields: the home-node field in its upper bits and the line index in its lower bits. The controller serves only requests whose home field names this node. It handles one request at a time and signals `busy` while it works.

When nobody holds the line, the controller reads the line from its local store, returns it to the requester and records the requester as holder. When a different node holds the line, the controller moves ownership to the requester and sends the old holder a single transfer-and-invalidate command that names the requester. After that, only one node holds the line. When the requester is already the holder, the line is served again from the local store and the entry stays as it is. The local store is a small internal array. After reset, each word of the store holds a fixed pattern derived from the home ID and the line index.

Top module: `sodir_top`

## Requirements
- R1: After reset `busy` and `msg_valid` are 0, and every directory entry is not held. The first request to any line after a reset is served as an unheld line.
- R2: A request is taken on a rising edge where `req_valid` is 1, `busy` is 0 and the home field `req_addr[NODE_W+IDX_W-1:IDX_W]` equals `HOME_ID`. `busy` is 1 from the next cycle until the request completes.
- R3: A request whose home field differs from `HOME_ID` is ignored: `busy` stays 0, no message is sent, and no entry changes.
- R4: Request for an unheld line: exactly one message goes out with `msg_kind`=0 (data). Its destination and `msg_req` are the requester, `msg_line` is the index, and `msg_data` = (HOME_ID<<24) XOR (index*0x10003) XOR 0x5A5A0000. The entry then names the requester as holder.
- R5: Request for a line held by another node: exactly one message goes out with `msg_kind`=1 (transfer-and-invalidate). Its destination is the old holder, `msg_req` is the requester, `msg_line` is the index and `msg_data` is 0. The entry then names the requester.
- R6: Request from the node already recorded as holder: a data message as in R4, and the entry is left unchanged.
- R7: Every taken request yields exactly one message, valid for one cycle. `busy` is 0 in the cycle after that message.
- R8: The message is valid after a set number of rising edges, counted from the edge that took the request: 3 for an unheld line, 2 for a repeat request from the holder, 2 for a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_node | input | NODE_W | Requesting node ID |
| req_addr | input | NODE_W+IDX_W | Line address: home field above the line index |
| busy | output | 1 | A request is in progress; new requests wait |
| msg_valid | output | 1 | Outgoing message valid (one cycle) |
| msg_kind | output | 1 | 0 = data reply, 1 = transfer-and-invalidate |
| msg_dest | output | NODE_W | Destination node |
| msg_req | output | NODE_W | Node that asked for the line |
| msg_line | output | IDX_W | Line index |
| msg_data | output | LINE_W | Line contents (0 for a transfer command) |

## Verification
Every line index is requested in four passes, and each pass uses a different requester per line.
- A first pass on a fresh directory must give data replies with the stored pattern.
- A repeat from the same nodes tells a recorded holder apart from an unheld line by the latency.
- A pass from other nodes must give transfer commands aimed at the first holders.
- A final repeat confirms that ownership moved.

Requests with a foreign home field, and a full sweep after a second reset, separate ignored and cleared state from retained state.

// File: rtl/sodir_pkg.sv
package sodir_pkg;

  parameter int NODE_W = 8;
  parameter int IDX_W  = 6;
  parameter int LINE_W = 32;

  localparam int LADDR_W = NODE_W + IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic {
    MSG_DATA    = 1'b0,
    MSG_FWD_INV = 1'b1
  } msg_kind_e;

  typedef struct packed {
    logic              held;
    logic [NODE_W-1:0] owner;
  } dir_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEMREAD,
    ST_FORWARD,
    ST_UPDATE,
    ST_RESPOND
  } seq_state_e;

  // home-node field of a line address
  function automatic logic [NODE_W-1:0] home_of(input logic [LADDR_W-1:0] a);
    return a[LADDR_W-1 -: NODE_W];
  endfunction

  // line index field of a line address
  function automatic logic [IDX_W-1:0] index_of(input logic [LADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  // initial contents of a stored line
  function automatic logic [LINE_W-1:0] seed_word(input int unsigned home,
                                                  input int unsigned idx);
    logic [31:0] w;
    w = ((home & 32'hFF) << 24) ^ (idx * 32'h0001_0003) ^ 32'h5A5A_0000;
    return LINE_W'(w);
  endfunction

endpackage

// File: rtl/sodir_table.sv
module sodir_table
  import sodir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output dir_entry_t       rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  dir_entry_t       wr_entry
);

  logic [ENTRIES-1:0] held_q;
  logic [NODE_W-1:0]  owner_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      for (int i = 0; i < ENTRIES; i++) owner_q[i] <= '0;
    end else if (wr_en) begin
      held_q[wr_idx]  <= wr_entry.held;
      owner_q[wr_idx] <= wr_entry.owner;
    end
  end

  always_comb begin
    rd_entry.held  = held_q[rd_idx];
    rd_entry.owner = owner_q[rd_idx];
  end

  // R4/R5: a written entry is what a later lookup sees
  p_store_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (held_q[$past(wr_idx)] == $past(wr_entry.held)) &&
              (owner_q[$past(wr_idx)] == $past(wr_entry.owner)));

endmodule

// File: rtl/sodir_store.sv
module sodir_store
  import sodir_pkg::*;
#(
  parameter int unsigned HOME_ID = 'h5C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_word
);

  logic [LINE_W-1:0] mem_q [ENTRIES];
  logic [LINE_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= seed_word(HOME_ID, i);
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem_q[rd_idx];
    end
  end

  assign rd_word = rd_q;

  // R6: the read word holds until the next read
  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/sodir_seq.sv
module sodir_seq
  import sodir_pkg::*;
#(
  parameter int unsigned HOME_ID = 'h5C
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [NODE_W-1:0]  req_node,
  input  logic [LADDR_W-1:0] req_addr,
  output logic               busy,
  output logic [IDX_W-1:0]   tbl_rd_idx,
  input  dir_entry_t         tbl_rd_entry,
  output logic               tbl_wr_en,
  output logic [IDX_W-1:0]   tbl_wr_idx,
  output dir_entry_t         tbl_wr_entry,
  output logic               mem_rd_en,
  output logic [IDX_W-1:0]   mem_rd_idx,
  input  logic [LINE_W-1:0]  mem_rd_word,
  output logic               msg_valid,
  output msg_kind_e          msg_kind,
  output logic [NODE_W-1:0]  msg_dest,
  output logic [NODE_W-1:0]  msg_req,
  output logic [IDX_W-1:0]   msg_line,
  output logic [LINE_W-1:0]  msg_data
);

  localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_ID);

  seq_state_e        state_q, state_d;
  logic [NODE_W-1:0] cur_node_q;
  logic [IDX_W-1:0]  cur_idx_q;
  dir_entry_t        ent_q;
  logic              fwd_q;

  // named internal events
  logic home_ok_w, accept_w, other_hold_w, self_hit_w;

  assign home_ok_w    = (home_of(req_addr) == HOME);
  assign accept_w     = req_valid && (state_q == ST_IDLE) && home_ok_w;
  assign other_hold_w = tbl_rd_entry.held && (tbl_rd_entry.owner != cur_node_q);
  assign self_hit_w   = (state_q == ST_LOOKUP) && tbl_rd_entry.held &&
                        (tbl_rd_entry.owner == cur_node_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_w) state_d = ST_LOOKUP;
      ST_LOOKUP:  state_d = other_hold_w ? ST_UPDATE : ST_MEMREAD;
      ST_MEMREAD: state_d = ent_q.held ? ST_RESPOND : ST_UPDATE;
      ST_UPDATE:  state_d = fwd_q ? ST_FORWARD : ST_RESPOND;
      ST_FORWARD: state_d = ST_IDLE;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_node_q <= '0;
      cur_idx_q  <= '0;
      ent_q      <= '0;
      fwd_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        cur_node_q <= req_node;
        cur_idx_q  <= index_of(req_addr);
      end
      if (state_q == ST_LOOKUP) begin
        ent_q <= tbl_rd_entry;
        fwd_q <= other_hold_w;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign tbl_rd_idx = cur_idx_q;
  assign tbl_wr_idx = cur_idx_q;
  assign tbl_wr_en  = (state_q == ST_UPDATE);
  always_comb begin
    tbl_wr_entry.held  = 1'b1;
    tbl_wr_entry.owner = cur_node_q;
  end
  assign mem_rd_en  = (state_q == ST_MEMREAD);
  assign mem_rd_idx = cur_idx_q;

  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = MSG_DATA;
    msg_dest  = cur_node_q;
    msg_req   = cur_node_q;
    msg_line  = cur_idx_q;
    msg_data  = '0;
    if (state_q == ST_RESPOND) begin
      msg_valid = 1'b1;
      msg_data  = mem_rd_word;
    end else if (state_q == ST_FORWARD) begin
      msg_valid = 1'b1;
      msg_kind  = MSG_FWD_INV;
      msg_dest  = ent_q.owner;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy);

  p_foreign_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !home_ok_w) |=> !busy);

  p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> (!msg_valid && !busy));

  p_fwd_elsewhere_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MSG_FWD_INV) |-> (msg_dest != msg_req));

  p_self_keeps_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    self_hit_w |=> ##1 !tbl_wr_en);

  p_miss_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOOKUP) && !tbl_rd_entry.held) |=> ##2 msg_valid);

endmodule

// File: rtl/sodir_top.sv
module sodir_top
  import sodir_pkg::*;
#(
  parameter int unsigned HOME_ID = 'h5C
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [NODE_W-1:0]         req_node,
  input  logic [NODE_W+IDX_W-1:0]   req_addr,
  output logic                      busy,
  output logic                      msg_valid,
  output logic                      msg_kind,
  output logic [NODE_W-1:0]         msg_dest,
  output logic [NODE_W-1:0]         msg_req,
  output logic [IDX_W-1:0]          msg_line,
  output logic [LINE_W-1:0]         msg_data
);

  logic [IDX_W-1:0]  tbl_rd_idx, tbl_wr_idx, mem_rd_idx;
  dir_entry_t        tbl_rd_entry, tbl_wr_entry;
  logic              tbl_wr_en, mem_rd_en;
  logic [LINE_W-1:0] mem_rd_word;
  msg_kind_e         kind_w;

  sodir_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (tbl_rd_idx),
    .rd_entry (tbl_rd_entry),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_entry (tbl_wr_entry)
  );

  sodir_store #(.HOME_ID(HOME_ID)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (mem_rd_en),
    .rd_idx  (mem_rd_idx),
    .rd_word (mem_rd_word)
  );

  sodir_seq #(.HOME_ID(HOME_ID)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_node     (req_node),
    .req_addr     (req_addr),
    .busy         (busy),
    .tbl_rd_idx   (tbl_rd_idx),
    .tbl_rd_entry (tbl_rd_entry),
    .tbl_wr_en    (tbl_wr_en),
    .tbl_wr_idx   (tbl_wr_idx),
    .tbl_wr_entry (tbl_wr_entry),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_idx   (mem_rd_idx),
    .mem_rd_word  (mem_rd_word),
    .msg_valid    (msg_valid),
    .msg_kind     (kind_w),
    .msg_dest     (msg_dest),
    .msg_req      (msg_req),
    .msg_line     (msg_line),
    .msg_data     (msg_data)
  );

  assign msg_kind = kind_w;

  // R1: quiet outputs right after reset release
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !msg_valid));

  // R5: a transfer command never carries line data
  p_fwd_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind) |-> (msg_data == '0));

endmodule

// File: tb/sodir_top_test.sv
`timescale 1ns/1ps
module sodir_top_test;

  localparam int          NW   = 8;
  localparam int          IW   = 6;
  localparam int          NL   = 1 << IW;
  localparam logic [7:0]  HOME = 8'h5C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [NW-1:0] req_node = '0;
  logic [NW+IW-1:0] req_addr = '0;
  logic          busy, msg_valid, msg_kind;
  logic [NW-1:0] msg_dest, msg_req;
  logic [IW-1:0] msg_line;
  logic [31:0]   msg_data;

  always #4 clk = ~clk;   // 125 MHz

  sodir_top #(.HOME_ID(HOME)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_node(req_node),
    .req_addr(req_addr), .busy(busy), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_dest(msg_dest), .msg_req(msg_req),
    .msg_line(msg_line), .msg_data(msg_data)
  );

  int runs = 0, fails = 0;
  bit done = 0;

  logic          g_valid, g_kind;
  logic [NW-1:0] g_dest, g_req;
  logic [IW-1:0] g_line;
  logic [31:0]   g_data;
  int            g_lat;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint unsigned act, input longint unsigned exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int idx);
    logic [31:0] hi, mix;
    hi  = {HOME, 24'd0};
    mix = {16'(idx), 16'd0} + 32'(3 * idx);
    return hi ^ mix ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [7:0] first_node(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] second_node(input int i);
    return first_node(i) ^ 8'hA5;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issue a request that must be taken; captures the one message
  task automatic issue(input logic [7:0] node, input logic [IW-1:0] line);
    @(negedge clk);
    req_valid = 1'b1; req_node = node; req_addr = {HOME, line};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    g_valid = 0; g_lat = 0;
    for (int k = 1; k <= 12 && !g_valid; k++) begin
      @(posedge clk); @(negedge clk);
      if (msg_valid) begin
        g_valid = 1; g_lat = k; g_kind = msg_kind; g_dest = msg_dest;
        g_req = msg_req; g_line = msg_line; g_data = msg_data;
      end
    end
    chk(g_valid, "R7", "message produced", g_valid, 1);
    @(posedge clk); @(negedge clk);
    chk(!busy && !msg_valid, "R7", "idle after message", {busy, msg_valid}, 0);
  endtask

  task automatic expect_data(input string rq, input logic [7:0] node,
                             input int line, input int lat);
    issue(node, IW'(line));
    chk(g_kind == 1'b0, rq, "kind data", g_kind, 0);
    chk(g_dest == node && g_req == node, rq, "dest/req", {g_dest, g_req}, {node, node});
    chk(g_line == IW'(line), rq, "line", g_line, line);
    chk(g_data == pattern(line), rq, "data", g_data, pattern(line));
    chk(g_lat == lat, "R8", "latency", g_lat, lat);
  endtask

  task automatic expect_fwd(input logic [7:0] old_h, input logic [7:0] node,
                            input int line);
    issue(node, IW'(line));
    chk(g_kind == 1'b1, "R5", "kind fwd", g_kind, 1);
    chk(g_dest == old_h, "R5", "dest old holder", g_dest, old_h);
    chk(g_req == node, "R5", "requester field", g_req, node);
    chk(g_line == IW'(line), "R5", "line", g_line, line);
    chk(g_data == 32'd0, "R5", "data zero", g_data, 0);
    chk(g_lat == 2, "R8", "fwd latency", g_lat, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(!busy && !msg_valid, "R1", "reset outputs", {busy, msg_valid}, 0);

    // R4: fresh directory, every line unheld
    for (int i = 0; i < NL; i++) expect_data("R4", first_node(i), i, 3);
    // R6: repeat from holder, entry unchanged
    for (int i = 0; i < NL; i++) expect_data("R6", first_node(i), i, 2);
    // R5: other nodes ask, old holder is commanded
    for (int i = 0; i < NL; i++) expect_fwd(first_node(i), second_node(i), i);
    // R5: ownership moved to the second node
    for (int i = 0; i < NL; i++) expect_data("R5", second_node(i), i, 2);

    // R3: foreign home field ignored
    @(negedge clk);
    req_valid = 1'b1; req_node = 8'h77; req_addr = {HOME ^ 8'h01, 6'd0};
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!busy && !msg_valid, "R3", "foreign ignored", {busy, msg_valid}, 0);
    end
    req_valid = 1'b0;
    expect_fwd(second_node(0), 8'h77, 0);   // R3: entry 0 untouched

    // R1: second reset clears all entries
    do_reset();
    chk(!busy && !msg_valid, "R1", "reset outputs again", {busy, msg_valid}, 0);
    for (int i = 0; i < NL; i++) expect_data("R1", 8'h77, i, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule